// File: doc/BRIEF.md
# Temperature-Compensated Threshold Scaler

This block turns a nominal magnetic switch-point code into the threshold that should apply at the present die temperature. A permanent magnet's field weakens as it warms and strengthens as it cools, so a fixed threshold would move the switching distance over temperature. The block scales the nominal code by a material-dependent slope, referenced to 25 °C. Warm dies therefore get a lower threshold and cold dies a higher one.

Each strobe presents a signed temperature in whole degrees Celsius, a 2-bit slope selector and an unsigned nominal code. The temperature is first clamped to the supported range. The block then forms `nominal × (1 + slope × (T − 25))` in fixed point. The slope is held in parts per 100,000 per degree. The result is rounded to nearest and saturated to the code range. It appears two clock cycles after the strobe, together with a one-cycle valid flag. A new strobe is accepted every cycle. Operate and release thresholds share one instance by presenting them on alternate strobes, or use two instances.

Top module: `tcs_scaler`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `out_valid` is 0 and `out_code` is 0.
- R2: A strobe sampled on rising edge N makes `out_valid` high for exactly the cycle after edge N+1. Strobes on consecutive cycles give results on consecutive cycles, in the same order. Without a strobe, `out_valid` stays low.
- R3: Selector 0 (flat) gives `out_code` equal to `nom_code` at every temperature.
- R4: Selector 1 applies a slope of −35 parts per 100,000 per °C. For example, nominal 1000 at 125 °C gives 965.
- R5: Selector 2 applies a slope of −120 parts per 100,000 per °C. For example, nominal 500 at −40 °C gives 539.
- R6: Selector 3 applies −200 parts per 100,000 per °C. Nominal 80 gives 60 at 150 °C and 90 at −40 °C.
- R7: The result is `floor((nom × (100000 − k × (Tc − 25)) + 50000) / 100000)`, where k is the selected magnitude and Tc the clamped temperature. An exact half rounds up. A result is never above the nominal when Tc ≥ 25, and never below it when Tc ≤ 25 (before saturation).
- R8: `temp_c` is a two's-complement value. Values below −40 are treated as −40, and values above 175 as 175.
- R9: A result above 2^CW − 1 (1023 by default) is output as 1023, and a negative result as 0.
- R10: At exactly 25 °C, every selector returns the nominal code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: inputs below are valid this cycle |
| temp_c | input | 10 | Die temperature, signed, °C |
| tc_sel | input | 2 | Slope selector: 0 flat, 1 −35, 2 −120, 3 −200 (per 100,000 per °C) |
| nom_code | input | 10 | Nominal threshold code at 25 °C |
| out_valid | output | 1 | One-cycle flag: `out_code` holds a new result |
| out_code | output | 10 | Compensated threshold code |

## Verification
The bench aims at the corners where fixed-point scaling goes wrong.

- Exact half-way products test rounding. A truncating design would return one less, for example 7 instead of 8 for nominal 10 at 150 °C with the steepest slope.
- Temperatures far outside the clamp range test clamping. A design that skipped the clamp would compute 300 °C literally and give a visibly smaller code.
- A maximal nominal at −40 °C tests saturation. A design without it would wrap and output a small number instead of 1023.
- Back-to-back strobes test the pipeline. A design that stalled or reordered results would have them flagged in the wrong cycle or paired with the wrong expected value.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Magnet slope selector; numeric values match the 2-bit input code.
    typedef enum logic [1:0] {
        TC_FLAT  = 2'd0,
        TC_MILD  = 2'd1,
        TC_MID   = 2'd2,
        TC_STEEP = 2'd3
    } tc_sel_e;

    // Wide signed width used for the fixed-point product.
    localparam int ACC_W = 48;

endpackage

// File: rtl/tcs_temp_clamp.sv
// Clamps the temperature word and converts it to a signed offset from the reference point.
module tcs_temp_clamp #(
    parameter int TW    = 10,
    parameter int T_MIN = -40,
    parameter int T_MAX = 175,
    parameter int T_REF = 25
) (
    input  logic signed [TW-1:0] temp,
    output logic signed [TW-1:0] delta
);

    localparam logic signed [TW-1:0] LO  = TW'(T_MIN);
    localparam logic signed [TW-1:0] HI  = TW'(T_MAX);
    localparam logic signed [TW-1:0] REF = TW'(T_REF);

    logic signed [TW-1:0] bounded;

    always_comb begin
        if (temp < LO)
            bounded = LO;
        else if (temp > HI)
            bounded = HI;
        else
            bounded = temp;
        delta = bounded - REF;
    end

endmodule

// File: rtl/tcs_coef_sel.sv
// Maps the selector to an unsigned slope magnitude (parts per SCALE per degree).
module tcs_coef_sel
    import tcs_pkg::*;
#(
    parameter int KW      = 8,
    parameter int K_MILD  = 35,
    parameter int K_MID   = 120,
    parameter int K_STEEP = 200
) (
    input  tc_sel_e         sel,
    output logic [KW-1:0]   slope
);

    always_comb begin
        unique case (sel)
            TC_FLAT:  slope = '0;
            TC_MILD:  slope = KW'(K_MILD);
            TC_MID:   slope = KW'(K_MID);
            TC_STEEP: slope = KW'(K_STEEP);
            default:  slope = '0;
        endcase
    end

endmodule

// File: rtl/tcs_scale_core.sv
// Fixed-point scaling: nom * (SCALE - slope*delta), rounded half-up, saturated.
module tcs_scale_core
    import tcs_pkg::*;
#(
    parameter int CW    = 10,
    parameter int TW    = 10,
    parameter int KW    = 8,
    parameter int SCALE = 100000
) (
    input  logic [CW-1:0]        nom,
    input  logic signed [TW-1:0] delta,
    input  logic [KW-1:0]        slope,
    output logic [CW-1:0]        code
);

    localparam int AW = ACC_W;
    localparam logic signed [AW-1:0] SCALE_S = AW'(SCALE);
    localparam logic signed [AW-1:0] HALF_S  = AW'(SCALE / 2);
    localparam logic signed [AW-1:0] MAX_S   = AW'((64'd1 << CW) - 64'd1);

    logic signed [AW-1:0] k_ext, d_ext, n_ext;
    logic signed [AW-1:0] factor, prod, biased, quot;

    always_comb begin
        k_ext  = AW'($signed({1'b0, slope}));
        d_ext  = AW'(delta);
        n_ext  = AW'($signed({1'b0, nom}));
        factor = SCALE_S - (k_ext * d_ext);
        prod   = n_ext * factor;
        biased = prod + HALF_S;
        quot   = biased / SCALE_S;
        if (quot < 0)
            code = '0;
        else if (quot > MAX_S)
            code = '1;
        else
            code = CW'(quot);
    end

endmodule

// File: rtl/tcs_scaler.sv
// Two-stage temperature-compensated threshold scaler.
module tcs_scaler
    import tcs_pkg::*;
#(
    parameter int TW      = 10,
    parameter int CW      = 10,
    parameter int KW      = 8,
    parameter int T_MIN   = -40,
    parameter int T_MAX   = 175,
    parameter int T_REF   = 25,
    parameter int SCALE   = 100000,
    parameter int K_MILD  = 35,
    parameter int K_MID   = 120,
    parameter int K_STEEP = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] temp_c,
    input  logic [1:0]    tc_sel,
    input  logic [CW-1:0] nom_code,
    output logic          out_valid,
    output logic [CW-1:0] out_code
);

    localparam logic signed [TW-1:0] D_LO = TW'(T_MIN - T_REF);
    localparam logic signed [TW-1:0] D_HI = TW'(T_MAX - T_REF);

    // Stage A: clamp and slope lookup, registered.
    logic signed [TW-1:0] delta_c;
    logic [KW-1:0]        slope_c;

    tcs_temp_clamp #(
        .TW(TW), .T_MIN(T_MIN), .T_MAX(T_MAX), .T_REF(T_REF)
    ) u_clamp (
        .temp  ($signed(temp_c)),
        .delta (delta_c)
    );

    tcs_coef_sel #(
        .KW(KW), .K_MILD(K_MILD), .K_MID(K_MID), .K_STEEP(K_STEEP)
    ) u_coef (
        .sel   (tc_sel_e'(tc_sel)),
        .slope (slope_c)
    );

    logic                 a_valid;
    logic signed [TW-1:0] a_delta;
    logic [KW-1:0]        a_slope;
    logic [CW-1:0]        a_nom;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_delta <= '0;
            a_slope <= '0;
            a_nom   <= '0;
        end else begin
            a_valid <= in_valid;
            if (in_valid) begin
                a_delta <= delta_c;
                a_slope <= slope_c;
                a_nom   <= nom_code;
            end
        end
    end

    // Stage B: multiply, round, saturate, registered to the outputs.
    logic [CW-1:0] code_c;

    tcs_scale_core #(
        .CW(CW), .TW(TW), .KW(KW), .SCALE(SCALE)
    ) u_core (
        .nom   (a_nom),
        .delta (a_delta),
        .slope (a_slope),
        .code  (code_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= a_valid;
            if (a_valid)
                out_code <= code_c;
        end
    end

    // Checks on the pipeline.
    AST_LATENCY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid) else $error("strobe lost"); // R2
    AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid) else $error("spurious valid"); // R2
    AST_DELTA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (a_delta >= D_LO && a_delta <= D_HI)) else $error("clamp escaped"); // R8
    AST_FLAT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_slope == '0) |=> out_code == $past(a_nom)) else $error("flat changed code"); // R3
    AST_REF_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_delta == '0) |=> out_code == $past(a_nom)) else $error("reference changed code"); // R10
    AST_HOT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_delta >= 0) |=> out_code <= $past(a_nom)) else $error("hot raised code"); // R7
    AST_COLD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_delta <= 0) |=> out_code >= $past(a_nom)) else $error("cold lowered code"); // R7

endmodule

// File: tb/tcs_scaler_test.sv
`timescale 1ns/1ps
module tcs_scaler_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] temp_c = '0;
    logic [1:0] tc_sel = '0;
    logic [9:0] nom_code = '0;
    logic       out_valid;
    logic [9:0] out_code;

    always #2.5 clk = ~clk;

    tcs_scaler uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .temp_c(temp_c),
        .tc_sel(tc_sel), .nom_code(nom_code), .out_valid(out_valid), .out_code(out_code)
    );

    typedef struct {
        int    code;
        int    due;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model written from the requirements.
    function automatic int model(int t, int sel, int nom);
        int     tc, k;
        longint f, p, r;
        tc = (t < -40) ? -40 : ((t > 175) ? 175 : t);
        case (sel)
            0: k = 0;
            1: k = 35;
            2: k = 120;
            default: k = 200;
        endcase
        f = 100000 - longint'(k) * (tc - 25);
        p = longint'(nom) * f + 50000;
        r = p / 100000;
        if (r < 0) r = 0;
        if (r > 1023) r = 1023;
        return int'(r);
    endfunction

    task automatic issue(int t, int sel, int nom, string req);
        exp_t e;
        e.code = model(t, sel, nom);
        e.due  = cyc + 2;
        e.req  = req;
        q.push_back(e);
        in_valid = 1'b1;
        temp_c   = 10'(t);
        tc_sel   = 2'(sel);
        nom_code = 10'(nom);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (!out_valid) begin
                    n_bad++;
                    $display("FAIL %s (R2 timing): out_valid=%0d expected 1 at cycle %0d", e.req, out_valid, cyc);
                end else if (int'(out_code) != e.code) begin
                    n_bad++;
                    $display("FAIL %s: out_code=%0d expected %0d", e.req, out_code, e.code);
                end
            end else if (out_valid) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2: out_valid=1 expected 0 at cycle %0d", cyc);
            end
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run incomplete=1 expected 0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_code !== 10'd0) begin
            n_bad++;
            $display("FAIL R1: valid=%0d code=%0d expected 0 0", out_valid, out_code);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_code !== 10'd0) begin
            n_bad++;
            $display("FAIL R1 after release: valid=%0d code=%0d expected 0 0", out_valid, out_code);
        end

        issue(150, 3, 80, "R6 hot");          idle(3);
        issue(-40, 3, 80, "R6 cold");         idle(3);
        issue(-40, 0, 517, "R3 flat cold");
        issue(175, 0, 517, "R3 flat hot");    idle(3);
        issue(125, 1, 1000, "R4 mild");       idle(3);
        issue(-40, 2, 500, "R5 mid");         idle(3);
        issue(150, 3, 10, "R7 half up");
        issue(175, 1, 3, "R7 small");         idle(3);
        issue(-100, 3, 80, "R8 below");
        issue(300, 3, 80, "R8 above");
        issue(175, 3, 80, "R8 edge");         idle(3);
        issue(-40, 3, 1023, "R9 saturate");   idle(3);
        for (int s = 0; s < 4; s++) issue(25, s, 333, "R10 reference");
        idle(3);
        for (int t = -60; t <= 200; t += 13) issue(t, (t + 64) % 4, (t * 7 + 300) & 1023, "R7 sweep");
        idle(2);
        issue(60, 2, 700, "R2 isolated");     idle(6);

        if (q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2: pending=%0d expected 0", q.size());
        end
        summary();
    end

endmodule